// File: doc/BRIEF.md
# Display Interrupt Status Collector

This block holds the top-level interrupt status word of a display controller. It has two groups of flags. The first group records local events: start of frame, row event, timing generator stopped, power sequence finished, and output FIFO underflow. Each local flag is sticky. A read of this block's own address clears it. The second group holds one summary flag for each display layer and one for the post-processing unit. A summary flag is raised by a pending pulse from its unit. Only a read of that unit's own status address clears it.

Every input is a single-cycle pulse in the `clk_i` domain. The register-read port returns the status word in the same cycle as the read strobe. The clear takes effect on the next clock edge. If an event arrives in the same cycle as the read that clears its flag, the returned word does not show it, but the flag stays set so the event is kept. The status word is read-only and has no write port. The OR of all flags is brought out for downstream masking logic.

Top module: `disp_irq_status`

## Requirements
- R1: After reset (`rst_ni` low), every flag is 0, `rd_data_o` reads 0x00000000 and `irq_o` is 0.
- R2: A pulse on `loc_evt_i[k]` sets status bit k on the next edge, where k=0 is frame start, 1 is timing generator stopped, 2 is power sequence done, 3 is row event and 4 is FIFO underflow. The bit stays set until it is cleared as R3 describes.
- R3: While `rd_en_i` is high with `rd_addr_i` equal to 0x38, `rd_data_o` shows the flags held before that edge. Bits 0 to 4 are 0 after the edge.
- R4: If `loc_evt_i[k]` pulses in the same cycle as a status read, `rd_data_o` in that cycle does not show the new event, and bit k is 1 after the edge.
- R5: A pulse on `layer_evt_i[j]` sets a summary bit on the next edge: j=0 sets bit 8 (base), 1 sets bit 9 (overlay 1), 2 sets bit 10 (overlay 2), 3 sets bit 11 (high-end overlay) and 4 sets bit 13 (post-processing). A read of address 0x38 leaves the summary bits unchanged.
- R6: A summary bit clears on the edge that ends a read of its own unit's address: 0x40 for j=0, 0x44 for j=1, 0x48 for j=2, 0x4C for j=3 and 0x50 for j=4. A read of any other address leaves the bit unchanged.
- R7: If `layer_evt_i[j]` pulses in the same cycle as a read of unit j's address, summary bit j is 1 after the edge.
- R8: Bits 5 to 7, 12 and 14 to 31 of `rd_data_o` are always 0. `rd_data_o` is 0 in every cycle without a read of 0x38, including reads of the unit addresses.
- R9: `irq_o` is 1 exactly when at least one status flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| loc_evt_i | input | 5 | Local event pulses (bit order as in R2) |
| layer_evt_i | input | 5 | Unit pending pulses (order as in R5) |
| rd_en_i | input | 1 | Read strobe |
| rd_addr_i | input | 8 | Read address |
| rd_data_o | output | 32 | Status word, valid in the read cycle |
| irq_o | output | 1 | OR of all flags |

## Verification
Directed sequences raise each local event and each unit pulse on its own. This shows that every flag lands at its own bit position and that reading 0x38 clears only the local group. Unit reads are tried against the wrong unit's address and then the matching one, which tells a shared clear apart from a per-unit clear. Events are placed in the same cycle as their clearing read to confirm that both kinds of flag keep the event. Finally, a long run of random pulses and reads is compared on every cycle with a behavioural model, to catch interactions between set and clear.

// File: rtl/disp_irq_pkg.sv
package disp_irq_pkg;
  localparam int REG_W = 32;
  localparam int N_LOC = 5;
  localparam int N_SUM = 5;
  localparam logic [REG_W-1:0] VALID_MASK = 32'h0000_2F1F;

  // summary j -> word bit; post-processing skips bit 12
  function automatic int sum_bit(input int j);
    return (j == N_SUM-1) ? 13 : 8 + j;
  endfunction

  function automatic logic [REG_W-1:0] pack_status(input logic [N_LOC-1:0] loc,
                                                   input logic [N_SUM-1:0] sum);
    logic [REG_W-1:0] w;
    w = '0;
    w[N_LOC-1:0] = loc;
    for (int j = 0; j < N_SUM; j++) w[sum_bit(j)] = sum[j];
    return w;
  endfunction
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int N = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);
  for (genvar g = 0; g < N; g++) begin : g_flag
    logic q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= 1'b0;
      else         q <= set_i[g] | (q & ~clr_i[g]);  // set beats clear
    end
    assign flag_o[g] = q;
  end
endmodule

// File: rtl/irq_rd_decode.sv
module irq_rd_decode #(
  parameter int AW = 8,
  parameter int NU = 5,
  parameter logic [AW-1:0] STAT_ADDR = 8'h38,
  parameter logic [NU*AW-1:0] UNIT_ADDR = {8'h50, 8'h4C, 8'h48, 8'h44, 8'h40}
) (
  input  logic          rd_en_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic          stat_hit_o,
  output logic [NU-1:0] unit_hit_o
);
  assign stat_hit_o = rd_en_i && (rd_addr_i == STAT_ADDR);
  for (genvar g = 0; g < NU; g++) begin : g_unit
    assign unit_hit_o[g] = rd_en_i && (rd_addr_i == UNIT_ADDR[g*AW +: AW]);
  end
endmodule

// File: rtl/disp_irq_status.sv
module disp_irq_status
  import disp_irq_pkg::*;
#(
  parameter int AW = 8,
  parameter logic [AW-1:0] STAT_ADDR = 8'h38,
  parameter logic [N_SUM*AW-1:0] UNIT_ADDR = {8'h50, 8'h4C, 8'h48, 8'h44, 8'h40}
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_LOC-1:0] loc_evt_i,
  input  logic [N_SUM-1:0] layer_evt_i,
  input  logic             rd_en_i,
  input  logic [AW-1:0]    rd_addr_i,
  output logic [REG_W-1:0] rd_data_o,
  output logic             irq_o
);
  logic             stat_hit;
  logic [N_SUM-1:0] unit_hit;
  logic [N_LOC-1:0] loc_q;
  logic [N_SUM-1:0] sum_q;
  logic [REG_W-1:0] status_w;

  irq_rd_decode #(
    .AW(AW), .NU(N_SUM), .STAT_ADDR(STAT_ADDR), .UNIT_ADDR(UNIT_ADDR)
  ) u_dec (
    .rd_en_i   (rd_en_i),
    .rd_addr_i (rd_addr_i),
    .stat_hit_o(stat_hit),
    .unit_hit_o(unit_hit)
  );

  irq_flag_bank #(.N(N_LOC)) u_loc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (loc_evt_i),
    .clr_i ({N_LOC{stat_hit}}),
    .flag_o(loc_q)
  );

  irq_flag_bank #(.N(N_SUM)) u_sum (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (layer_evt_i),
    .clr_i (unit_hit),
    .flag_o(sum_q)
  );

  assign status_w  = pack_status(loc_q, sum_q);
  // returned word is pre-clear state; same-cycle events land after the edge
  assign rd_data_o = stat_hit ? status_w : '0;
  assign irq_o     = |status_w;
endmodule

// File: rtl/disp_irq_status_chk.sv
module disp_irq_status_chk
  import disp_irq_pkg::*;
#(
  parameter int AW = 8,
  parameter logic [AW-1:0] STAT_ADDR = 8'h38,
  parameter logic [N_SUM*AW-1:0] UNIT_ADDR = {8'h50, 8'h4C, 8'h48, 8'h44, 8'h40}
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [N_LOC-1:0] loc_evt_i,
  input logic [N_SUM-1:0] layer_evt_i,
  input logic             rd_en_i,
  input logic [AW-1:0]    rd_addr_i,
  input logic [REG_W-1:0] rd_data_o,
  input logic             irq_o,
  input logic [N_LOC-1:0] loc_q,
  input logic [N_SUM-1:0] sum_q
);
  logic stat_rd;
  assign stat_rd = rd_en_i && (rd_addr_i == STAT_ADDR);

  for (genvar g = 0; g < N_LOC; g++) begin : g_loc
    assert_loc_set_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      loc_evt_i[g] |=> loc_q[g]);
    assert_loc_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!loc_evt_i[g] && !stat_rd) |=> $stable(loc_q[g]));
    assert_loc_clr_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (stat_rd && !loc_evt_i[g]) |=> !loc_q[g]);
  end

  for (genvar g = 0; g < N_SUM; g++) begin : g_sum
    logic own_rd;
    assign own_rd = rd_en_i && (rd_addr_i == UNIT_ADDR[g*AW +: AW]);
    assert_sum_set_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      layer_evt_i[g] |=> sum_q[g]);
    assert_sum_keep_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!layer_evt_i[g] && !own_rd) |=> $stable(sum_q[g]));
    assert_sum_clr_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (own_rd && !layer_evt_i[g]) |=> !sum_q[g]);
  end

  assert_spare_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_o & ~VALID_MASK) == '0);
  assert_idle_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stat_rd |-> (rd_data_o == '0));
  assert_irq_seen_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_o != '0) |-> irq_o);
  assert_irq_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (loc_q == '0 && sum_q == '0) |-> !irq_o);
endmodule

bind disp_irq_status disp_irq_status_chk #(
  .AW(AW), .STAT_ADDR(STAT_ADDR), .UNIT_ADDR(UNIT_ADDR)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .loc_evt_i  (loc_evt_i),
  .layer_evt_i(layer_evt_i),
  .rd_en_i    (rd_en_i),
  .rd_addr_i  (rd_addr_i),
  .rd_data_o  (rd_data_o),
  .irq_o      (irq_o),
  .loc_q      (loc_q),
  .sum_q      (sum_q)
);

// File: tb/disp_irq_status_test.sv
module disp_irq_status_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] A_STAT = 8'h38;
  localparam logic [7:0] A_UNIT [5] = '{8'h40, 8'h44, 8'h48, 8'h4C, 8'h50};
  localparam int SUM_POS [5] = '{8, 9, 10, 11, 13};

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [4:0]  loc_evt = '0;
  logic [4:0]  layer_evt = '0;
  logic        rd_en = 1'b0;
  logic [7:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        irq;

  int checks = 0;
  int errors = 0;
  logic [31:0] model = '0;
  logic [31:0] obs;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  disp_irq_status uut (
    .clk_i(clk), .rst_ni(rst_ni), .loc_evt_i(loc_evt), .layer_evt_i(layer_evt),
    .rd_en_i(rd_en), .rd_addr_i(rd_addr), .rd_data_o(rd_data), .irq_o(irq)
  );

  task automatic check(input logic [31:0] got, input logic [31:0] exp, input string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  // one cycle: drive after negedge, compare to model, then advance model past posedge
  task automatic cyc(input logic [4:0] e, input logic [4:0] l, input logic rd,
                     input logic [7:0] a, output logic [31:0] seen);
    logic [31:0] exp_rd;
    loc_evt = e; layer_evt = l; rd_en = rd; rd_addr = a;
    #1;
    exp_rd = (rd && a == A_STAT) ? model : 32'h0;
    check(rd_data, exp_rd, "R8 model rd_data");
    check({31'h0, irq}, {31'h0, model != 0}, "R9 model irq");
    seen = rd_data;
    @(posedge clk);
    if (rd && a == A_STAT) model[4:0] = 5'h0;
    for (int j = 0; j < 5; j++) if (rd && a == A_UNIT[j]) model[SUM_POS[j]] = 1'b0;
    model[4:0] = model[4:0] | e;
    for (int j = 0; j < 5; j++) if (l[j]) model[SUM_POS[j]] = 1'b1;
    @(negedge clk);
  endtask

  task automatic idle();
    logic [31:0] s;
    cyc('0, '0, 1'b0, 8'h0, s);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(rd_data, 32'h0, "R1 rd_data in reset");
    check({31'h0, irq}, 32'h0, "R1 irq in reset");
    rst_ni = 1'b1;
    @(negedge clk);
    cyc('0, '0, 1'b1, A_STAT, obs);
    check(obs, 32'h0, "R1 first read");

    // R2 / R3: each local event alone
    for (int k = 0; k < 5; k++) begin
      cyc(5'(1 << k), '0, 1'b0, 8'h0, obs);
      idle();
      cyc('0, '0, 1'b1, A_STAT, obs);
      check(obs, 32'(1 << k), "R2 local bit position");
      cyc('0, '0, 1'b1, A_STAT, obs);
      check(obs, 32'h0, "R3 local cleared by read");
    end

    // R5 / R6: each unit alone
    for (int j = 0; j < 5; j++) begin
      cyc('0, 5'(1 << j), 1'b0, 8'h0, obs);
      check({31'h0, irq}, 32'h1, "R9 irq with summary");
      cyc('0, '0, 1'b1, A_STAT, obs);
      check(obs, 32'(1) << SUM_POS[j], "R5 summary bit position");
      cyc('0, '0, 1'b1, A_STAT, obs);
      check(obs, 32'(1) << SUM_POS[j], "R5 summary survives status read");
      cyc('0, '0, 1'b1, A_UNIT[(j + 1) % 5], obs);
      check(obs, 32'h0, "R8 unit read returns zero");
      cyc('0, '0, 1'b1, A_STAT, obs);
      check(obs, 32'(1) << SUM_POS[j], "R6 other unit read leaves bit");
      cyc('0, '0, 1'b1, A_UNIT[j], obs);
      cyc('0, '0, 1'b1, A_STAT, obs);
      check(obs, 32'h0, "R6 own unit read clears bit");
      check({31'h0, irq}, 32'h0, "R9 irq low when empty");
    end

    // R4: local collision
    cyc(5'b00001, '0, 1'b0, 8'h0, obs);
    cyc(5'b01000, '0, 1'b1, A_STAT, obs);
    check(obs, 32'h1, "R4 read excludes same-cycle event");
    cyc('0, '0, 1'b1, A_STAT, obs);
    check(obs, 32'h8, "R4 same-cycle event kept");

    // R7: summary collision
    cyc('0, 5'b00100, 1'b0, 8'h0, obs);
    cyc('0, 5'b00100, 1'b1, A_UNIT[2], obs);
    cyc('0, '0, 1'b1, A_STAT, obs);
    check(obs, 32'h400, "R7 pulse with own read keeps bit");
    cyc('0, '0, 1'b1, A_UNIT[2], obs);

    // all flags at once; spare bits stay zero
    cyc(5'h1F, 5'h1F, 1'b0, 8'h0, obs);
    cyc('0, '0, 1'b1, A_STAT, obs);
    check(obs, 32'h0000_2F1F, "R8 full word, spare bits zero");

    // random traffic against the model
    for (int n = 0; n < 4000; n++) begin
      logic [4:0] e, l;
      logic [7:0] a;
      int pick;
      e = 5'($urandom) & 5'($urandom);
      l = 5'($urandom) & 5'($urandom) & 5'($urandom);
      pick = $urandom_range(0, 7);
      a = (pick < 3) ? A_STAT : (pick < 7) ? A_UNIT[$urandom_range(0, 4)] : 8'h3C;
      cyc(e, l, ($urandom_range(0, 2) != 0), a, obs);
    end

    // async reset mid-run
    cyc(5'h1F, 5'h1F, 1'b0, 8'h0, obs);
    rst_ni = 1'b0;
    #1;
    check({31'h0, irq}, 32'h0, "R1 irq after reset");
    model = '0;
    @(negedge clk);
    rst_ni = 1'b1;
    cyc('0, '0, 1'b1, A_STAT, obs);
    check(obs, 32'h0, "R1 word after reset");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule